// File: doc/BRIEF.md
# Video Memory Copy and Fill Engine

This block moves 16-bit words around a word-addressed video memory with a 20-bit address space. Software loads seven 16-bit parameter words and a command word. Writing the command starts one of three jobs: a linear copy, a rectangular copy in which source and destination rows sit a fixed pitch apart, or a linear fill with a constant word. While the job runs, a ready flag is low. It goes high again once the last word has been written.

The memory side is one request/acknowledge port. Each transaction moves one word, either a read or a write. A copy reads a word from the source and then writes it to the destination. A fill only writes. Command codes that belong to the drawing functions, and codes this block does not recognise, are accepted and complete with no memory traffic.

Top module: `vmove_engine`

## Requirements
- R1: After a synchronous active-low reset, `ready` is 1 and `mem_req` is 0.
- R2: `ready` is 0 from the clock edge that accepts a job until the edge that takes the acknowledge of the job's last write. It is 1 at all other times.
- R3: Only `cmd_word` bits 6:0 select the job, and bits 15:7 are ignored. The codes are 0x06 linear copy, 0x07 rectangular copy and 0x08 fill. Every other value, including 0x00 and 0x01 to 0x05, completes at once with no memory access and `ready` stays 1.
- R4: A pointer is `{high[3:0], low}` taken from two parameter slots. Bits 15:4 of the high slot are ignored.
- R5: Linear copy uses slot 0 as source low, 1 as source high, 2 as destination low, 3 as destination high and 4 as word count. Each word is read from the source and then written to the destination, and both addresses go up by 1 per word.
- R6: Rectangular copy uses slots 0 to 3 as in R5, slot 4 as width in words, slot 5 as height in lines and slot 6 as pitch in words. After each row both row-start addresses advance by the pitch. A pitch of 0 means a pitch equal to the width.
- R7: Fill uses slot 0 as destination low, 1 as destination high, 2 as word count and 3 as the fill word. It issues only writes, one per word, at ascending addresses.
- R8: A word count, width or height of 0 completes at once with no memory access, and `ready` stays 1.
- R9: Addresses wrap modulo 2^20.
- R10: A command written while `ready` is 0 is ignored. The running job finishes unchanged and no extra job follows.
- R11: Once raised, `mem_req` stays high with stable `mem_we`, `mem_addr` and `mem_wdata` until `mem_ack`. Each acknowledge completes exactly one transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_wr | input | 1 | One-cycle strobe that writes the command word |
| cmd_word | input | 16 | Command word, code in bits 6:0 |
| prm_flat | input | 112 | Seven 16-bit parameter slots, slot i at bits 16*i+15:16*i |
| ready | output | 1 | 1 when idle and able to accept a command |
| mem_req | output | 1 | Memory transaction request |
| mem_we | output | 1 | 1 for a write, 0 for a read |
| mem_addr | output | 20 | Word address |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, valid in the acknowledge cycle |
| mem_ack | input | 1 | Completes the current transaction |

## Verification
The bench sweeps small counts, widths, heights and both pitch choices over several acknowledge latencies. It compares the whole memory with an arithmetic model and counts every transfer, so a wrong row pitch or an extra or missing word shows up as a corrupted word or a wrong count. A source range that crosses the top of the address space checks the wrap: a design that carries past bit 19 would put the last write address out of range. Busy-time commands, zero sizes, the drawing codes and set upper code bits are also tested. A design that acted on any of them would start a second job, touch memory, or treat 0x86 as a no-op.

// File: rtl/vmove_pkg.sv
// Package: shared widths, command codes and the decoded job record for the
// video memory copy/fill engine. Assumes 16-bit words and 20-bit addresses.
package vmove_pkg;

    localparam int ADDR_W  = 20;
    localparam int DATA_W  = 16;
    localparam int PRM_N   = 7;
    localparam int CODE_W  = 7;
    localparam int HI_W    = ADDR_W - DATA_W;

    localparam logic [CODE_W-1:0] CODE_LCOPY = 7'h06;
    localparam logic [CODE_W-1:0] CODE_RCOPY = 7'h07;
    localparam logic [CODE_W-1:0] CODE_FILL  = 7'h08;

    typedef enum logic [1:0] {
        OP_NONE  = 2'd0,
        OP_LCOPY = 2'd1,
        OP_RCOPY = 2'd2,
        OP_FILL  = 2'd3
    } op_e;

    typedef struct packed {
        op_e               op;
        logic [ADDR_W-1:0] src;
        logic [ADDR_W-1:0] dst;
        logic [DATA_W-1:0] cols;
        logic [DATA_W-1:0] rows;
        logic [DATA_W-1:0] pitch;
        logic [DATA_W-1:0] fill;
    } job_t;

    // Join a low slot and the low nibble of a high slot into one pointer.
    function automatic logic [ADDR_W-1:0] mk_ptr(input logic [DATA_W-1:0] lo,
                                                 input logic [DATA_W-1:0] hi);
        return {hi[HI_W-1:0], lo};
    endfunction

endpackage

// File: rtl/vmove_decode.sv
// Module: vmove_decode
// Turns the command word and the seven parameter slots into a job record.
// It is purely combinational. Unknown codes and zero sizes are flagged empty
// so that the top accepts them without starting the sequencer.
module vmove_decode
    import vmove_pkg::*;
(
    input  logic [DATA_W-1:0]       cmd_word,
    input  logic [PRM_N*DATA_W-1:0] prm_flat,
    output job_t                    job,
    output logic                    job_empty
);

    logic [DATA_W-1:0] slot [PRM_N];
    logic [CODE_W-1:0] code;

    // Split the flat parameter bus into slots.
    generate
        for (genvar gi = 0; gi < PRM_N; gi++) begin : g_slot
            assign slot[gi] = prm_flat[gi*DATA_W +: DATA_W];
        end
    endgenerate

    assign code = cmd_word[CODE_W-1:0];

    // Map slots to job fields according to the command code.
    always_comb begin
        job = '0;
        job.op = OP_NONE;
        unique case (code)
            CODE_LCOPY: begin
                job.op    = OP_LCOPY;
                job.src   = mk_ptr(slot[0], slot[1]);
                job.dst   = mk_ptr(slot[2], slot[3]);
                job.cols  = slot[4];
                job.rows  = DATA_W'(1);
                job.pitch = slot[4];
            end
            CODE_RCOPY: begin
                job.op    = OP_RCOPY;
                job.src   = mk_ptr(slot[0], slot[1]);
                job.dst   = mk_ptr(slot[2], slot[3]);
                job.cols  = slot[4];
                job.rows  = slot[5];
                job.pitch = (slot[6] == '0) ? slot[4] : slot[6];
            end
            CODE_FILL: begin
                job.op    = OP_FILL;
                job.dst   = mk_ptr(slot[0], slot[1]);
                job.cols  = slot[2];
                job.rows  = DATA_W'(1);
                job.pitch = slot[2];
                job.fill  = slot[3];
            end
            default: job.op = OP_NONE;
        endcase
    end

    // A job with no operation or a zero dimension moves nothing.
    assign job_empty = (job.op == OP_NONE) || (job.cols == '0) || (job.rows == '0);

endmodule

// File: rtl/vmove_walker.sv
// Module: vmove_walker
// Address generator. It keeps the column and row counters, the row-start
// pointers and the current pointers for both sides. It advances once per
// completed write. Assumes the sizes loaded are non-zero. Sums wrap at 2^20.
module vmove_walker
    import vmove_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  job_t              job_in,
    input  logic              step,
    output logic [ADDR_W-1:0] src_addr,
    output logic [ADDR_W-1:0] dst_addr,
    output logic              last
);

    logic [DATA_W-1:0] col_q, row_q, cols_q, rows_q, pitch_q;
    logic [ADDR_W-1:0] src_row_q, dst_row_q, src_ptr_q, dst_ptr_q;
    logic [ADDR_W-1:0] pitch_ext;
    logic              row_end;

    assign pitch_ext = {{HI_W{1'b0}}, pitch_q};
    assign row_end   = (col_q == cols_q - 1'b1);
    assign last      = row_end && (row_q == rows_q - 1'b1);
    assign src_addr  = src_ptr_q;
    assign dst_addr  = dst_ptr_q;

    // Load a new job, or move to the next word or the next row.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            col_q     <= '0;
            row_q     <= '0;
            cols_q    <= '0;
            rows_q    <= '0;
            pitch_q   <= '0;
            src_row_q <= '0;
            dst_row_q <= '0;
            src_ptr_q <= '0;
            dst_ptr_q <= '0;
        end else if (load) begin
            col_q     <= '0;
            row_q     <= '0;
            cols_q    <= job_in.cols;
            rows_q    <= job_in.rows;
            pitch_q   <= job_in.pitch;
            src_row_q <= job_in.src;
            dst_row_q <= job_in.dst;
            src_ptr_q <= job_in.src;
            dst_ptr_q <= job_in.dst;
        end else if (step) begin
            if (row_end) begin
                col_q     <= '0;
                row_q     <= row_q + 1'b1;
                src_row_q <= src_row_q + pitch_ext;
                dst_row_q <= dst_row_q + pitch_ext;
                src_ptr_q <= src_row_q + pitch_ext;
                dst_ptr_q <= dst_row_q + pitch_ext;
            end else begin
                col_q     <= col_q + 1'b1;
                src_ptr_q <= src_ptr_q + 1'b1;
                dst_ptr_q <= dst_ptr_q + 1'b1;
            end
        end
    end

    AST_COL_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load && !row_end) |=> (dst_ptr_q == $past(dst_ptr_q) + 1'b1)); // R5

    AST_ROW_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load && row_end && !last) |=> (col_q == '0 && row_q == $past(row_q) + 1'b1
                                                 && dst_ptr_q == dst_row_q)); // R6

endmodule

// File: rtl/vmove_port.sv
// Module: vmove_port
// Sequencer and memory port. A copy runs read-then-write per word and a fill
// runs writes only. The request and its address, direction and data are held
// until acknowledged. Assumes the walker's pointers are valid from the cycle
// after start.
module vmove_port
    import vmove_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              start_fill,
    input  logic              last,
    input  logic [ADDR_W-1:0] src_addr,
    input  logic [ADDR_W-1:0] dst_addr,
    input  logic [DATA_W-1:0] fill_val,
    input  logic              mem_ack,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              step,
    output logic              idle
);

    typedef enum logic [1:0] {S_IDLE, S_READ, S_WRITE} state_e;

    state_e            state_q;
    logic              fill_q;
    logic [DATA_W-1:0] hold_q;

    assign idle      = (state_q == S_IDLE);
    assign mem_req   = !idle;
    assign mem_we    = (state_q == S_WRITE);
    assign mem_addr  = mem_we ? dst_addr : src_addr;
    assign mem_wdata = fill_q ? fill_val : hold_q;
    assign step      = (state_q == S_WRITE) && mem_ack;

    // Step through read and write phases on each acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            fill_q  <= 1'b0;
        end else begin
            unique case (state_q)
                S_IDLE: if (start) begin
                    fill_q  <= start_fill;
                    state_q <= start_fill ? S_WRITE : S_READ;
                end
                S_READ: if (mem_ack) state_q <= S_WRITE;
                S_WRITE: if (mem_ack) begin
                    if (last)        state_q <= S_IDLE;
                    else if (fill_q) state_q <= S_WRITE;
                    else             state_q <= S_READ;
                end
                default: state_q <= S_IDLE;
            endcase
        end
    end

    // Capture the word read during a copy.
    always_ff @(posedge clk) begin
        if (!rst_n)                            hold_q <= '0;
        else if (state_q == S_READ && mem_ack) hold_q <= mem_rdata;
    end

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_we) && $stable(mem_addr)
                                   && $stable(mem_wdata))); // R11

    AST_FILL_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_q && mem_req) |-> mem_we); // R7

    AST_READ_THEN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_we && mem_ack) |=> (mem_req && mem_we)); // R5

endmodule

// File: rtl/vmove_engine.sv
// Module: vmove_engine (top)
// Command-driven copy/fill engine for a 20-bit word-addressed video memory.
// A command strobe is taken only while ready. Empty or no-op commands are
// taken and finish in the same cycle without touching memory.
module vmove_engine
    import vmove_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cmd_wr,
    input  logic [DATA_W-1:0]       cmd_word,
    input  logic [PRM_N*DATA_W-1:0] prm_flat,
    output logic                    ready,
    output logic                    mem_req,
    output logic                    mem_we,
    output logic [ADDR_W-1:0]       mem_addr,
    output logic [DATA_W-1:0]       mem_wdata,
    input  logic [DATA_W-1:0]       mem_rdata,
    input  logic                    mem_ack
);

    job_t              job_new, job_q;
    logic              job_empty, accept, step, last, idle;
    logic [ADDR_W-1:0] src_addr, dst_addr;

    vmove_decode u_decode (
        .cmd_word  (cmd_word),
        .prm_flat  (prm_flat),
        .job       (job_new),
        .job_empty (job_empty)
    );

    assign ready  = idle;
    assign accept = cmd_wr && idle && !job_empty;

    // Keep the accepted job, whose fill word is needed for the whole job.
    always_ff @(posedge clk) begin
        if (!rst_n)      job_q <= '0;
        else if (accept) job_q <= job_new;
    end

    vmove_walker u_walker (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (accept),
        .job_in   (job_new),
        .step     (step),
        .src_addr (src_addr),
        .dst_addr (dst_addr),
        .last     (last)
    );

    vmove_port u_port (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (accept),
        .start_fill (job_new.op == OP_FILL),
        .last       (last),
        .src_addr   (src_addr),
        .dst_addr   (dst_addr),
        .fill_val   (job_q.fill),
        .mem_ack    (mem_ack),
        .mem_rdata  (mem_rdata),
        .mem_req    (mem_req),
        .mem_we     (mem_we),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata),
        .step       (step),
        .idle       (idle)
    );

    AST_BUSY_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> !ready); // R2

    AST_BUSY_CMD_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && !ready) |=> $stable(job_q)); // R10

    AST_EMPTY_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && cmd_wr && job_empty) |=> !mem_req); // R8

endmodule

// File: tb/vmove_engine_tb_top.sv
// Bench for vmove_engine: sweeps copy and fill jobs over several acknowledge
// latencies against an arithmetic memory model.
module vmove_engine_tb_top;

    localparam int MW = 12;
    localparam int MN = 1 << MW;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cmd_wr = 1'b0;
    logic [15:0]  cmd_word = '0;
    logic [111:0] prm_flat = '0;
    logic         ready, mem_req, mem_we, mem_ack;
    logic [19:0]  mem_addr;
    logic [15:0]  mem_wdata, mem_rdata;

    int tests = 0;
    int fails = 0;

    logic [15:0] mem  [MN];
    logic [15:0] expm [MN];
    int          lat = 0;
    int          wait_cnt;
    int          acc_cnt;
    logic        load_req = 1'b0;
    logic [15:0] load_seed = '0;
    logic        first_wr_seen;
    logic [19:0] first_wr, last_wr;
    int          hold_err = 0;
    int          cyc = 0;

    always #5 clk = ~clk;

    vmove_engine dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_wr    (cmd_wr),
        .cmd_word  (cmd_word),
        .prm_flat  (prm_flat),
        .ready     (ready),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_rdata (mem_rdata),
        .mem_ack   (mem_ack)
    );

    function automatic logic [15:0] pat(int i, logic [15:0] s);
        return 16'(i * 40503) ^ s;
    endfunction

    // Memory model: acknowledges after lat wait cycles and logs write addresses.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (load_req) begin
            for (int i = 0; i < MN; i++) mem[i] <= pat(i, load_seed);
            acc_cnt       <= 0;
            first_wr_seen <= 1'b0;
        end
        if (!rst_n) begin
            mem_ack  <= 1'b0;
            wait_cnt <= 0;
            mem_rdata <= '0;
        end else if (mem_ack) begin
            mem_ack  <= 1'b0;
            wait_cnt <= 0;
        end else if (mem_req) begin
            if (wait_cnt >= lat) begin
                mem_ack <= 1'b1;
                acc_cnt <= acc_cnt + 1;
                if (mem_we) begin
                    mem[mem_addr[MW-1:0]] <= mem_wdata;
                    if (!first_wr_seen) first_wr <= mem_addr;
                    first_wr_seen <= 1'b1;
                    last_wr <= mem_addr;
                end else begin
                    mem_rdata <= mem[mem_addr[MW-1:0]];
                end
            end else begin
                wait_cnt <= wait_cnt + 1;
            end
        end
    end

    // Handshake monitor for R11, sampled on the falling edge.
    logic        p_req = 1'b0, p_ack = 1'b0, p_we = 1'b0;
    logic [19:0] p_addr = '0;
    logic [15:0] p_wd = '0;
    always @(negedge clk) begin
        if (rst_n && p_req && !p_ack &&
            (!mem_req || mem_we != p_we || mem_addr != p_addr || mem_wdata != p_wd))
            hold_err <= hold_err + 1;
        p_req <= mem_req; p_ack <= mem_ack; p_we <= mem_we;
        p_addr <= mem_addr; p_wd <= mem_wdata;
    end

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic preload(input logic [15:0] s);
        @(negedge clk);
        load_seed = s; load_req = 1'b1;
        @(negedge clk);
        load_req = 1'b0;
        for (int i = 0; i < MN; i++) expm[i] = pat(i, s);
    endtask

    task automatic set_prm(input logic [15:0] p0, p1, p2, p3, p4, p5, p6);
        prm_flat = {p6, p5, p4, p3, p2, p1, p0};
    endtask

    task automatic issue(input logic [15:0] code);
        @(negedge clk);
        cmd_word = code; cmd_wr = 1'b1;
        @(negedge clk);
        cmd_wr = 1'b0;
    endtask

    task automatic wait_idle();
        while (!ready && cyc < 150000) @(negedge clk);
    endtask

    // Model a rectangular copy word by word in the design's order.
    task automatic model_copy(input logic [19:0] s, d, input int w, h, pitch);
        logic [19:0] sr = s, dr = d;
        for (int r = 0; r < h; r++) begin
            for (int c = 0; c < w; c++)
                expm[20'(dr + 20'(c)) & 20'(MN-1)] = expm[20'(sr + 20'(c)) & 20'(MN-1)];
            sr = sr + 20'(pitch); dr = dr + 20'(pitch);
        end
    endtask

    task automatic mem_check(input string req);
        int bad = 0, first = -1;
        for (int i = 0; i < MN; i++) if (mem[i] !== expm[i]) begin
            bad++; if (first < 0) first = i;
        end
        check(bad == 0, req, "memory image",
              (first < 0) ? 0 : mem[first], (first < 0) ? 0 : expm[first]);
    endtask

    // Run a copy (linear when h == 0) and check memory, traffic and addresses.
    task automatic run_copy(input string req, input logic [19:0] s, d,
                            input int w, h, stride);
        int pitch = (stride == 0) ? w : stride;
        int hh = (h == 0) ? 1 : h;
        logic [19:0] lastd = d + 20'((hh - 1) * pitch + w - 1);
        if (h == 0) set_prm(s[15:0], {12'h0, s[19:16]}, d[15:0], {12'h0, d[19:16]},
                            16'(w), 16'h0, 16'h0);
        else        set_prm(s[15:0], {12'h0, s[19:16]}, d[15:0], {12'h0, d[19:16]},
                            16'(w), 16'(h), 16'(stride));
        issue((h == 0) ? 16'h0006 : 16'h0007);
        check(ready == 1'b0, "R2", "ready after start", ready, 0);
        wait_idle();
        model_copy(s, d, w, hh, pitch);
        mem_check(req);
        check(acc_cnt == 2 * w * hh, req, "transfer count", acc_cnt, 2 * w * hh);
        check(first_wr == d && last_wr == lastd, req, "write span",
              {first_wr, last_wr}, {d, lastd});
    endtask

    task automatic run_fill(input logic [19:0] d, input int n, input logic [15:0] v);
        set_prm(d[15:0], {12'h0, d[19:16]}, 16'(n), v, 16'h0, 16'h0, 16'h0);
        issue(16'h0008);
        check(ready == 1'b0, "R2", "ready after fill start", ready, 0);
        wait_idle();
        for (int i = 0; i < n; i++) expm[20'(d + 20'(i)) & 20'(MN-1)] = v;
        mem_check("R7");
        check(acc_cnt == n, "R7", "fill write count", acc_cnt, n);
        check(last_wr == d + 20'(n - 1), "R7", "fill last address", last_wr, d + 20'(n - 1));
    endtask

    // Command expected to do nothing: ready stays 1, no traffic.
    task automatic run_empty(input string req, input logic [15:0] code);
        bit stayed = 1'b1;
        issue(code);
        for (int i = 0; i < 8; i++) begin
            if (!ready || mem_req) stayed = 1'b0;
            @(negedge clk);
        end
        check(stayed && acc_cnt == 0, req, "no-op command", acc_cnt, 0);
    endtask

    // Watchdog: an expired run is a failed check and still reports.
    initial begin
        wait (cyc >= 150000);
        fails++; tests++;
        $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(ready == 1'b1 && mem_req == 1'b0, "R1", "reset outputs", {ready, mem_req}, 2'b10);
        rst_n = 1'b1;
        @(negedge clk);

        // R5: linear copy sweep over counts and latencies.
        for (int l = 0; l < 3; l++)
            for (int n = 1; n <= 8; n++) begin
                lat = l;
                preload(16'(n * 7 + l));
                run_copy("R5", 20'h3_0100 + 20'(n), 20'h3_0400 + 20'(n * 3), n, 0, 0);
            end

        // R6: rectangular copy sweep, pitch 0 (packed) and wider pitch.
        for (int w = 1; w <= 4; w++)
            for (int h = 1; h <= 3; h++)
                for (int sm = 0; sm < 2; sm++) begin
                    lat = (w + h + sm) % 3;
                    preload(16'(w * 31 + h * 5 + sm));
                    run_copy("R6", 20'h5_0200, 20'hA_0600 + 20'(w), w, h,
                             (sm == 0) ? 0 : w + 3);
                end

        // R7: fill sweep.
        for (int n = 1; n <= 6; n++) begin
            lat = n % 2;
            preload(16'(n + 100));
            run_fill(20'h7_0800 + 20'(n), n, 16'(16'hC3A0 + n));
        end

        // R9: copy whose source and destination cross the top of the space.
        lat = 1;
        preload(16'h55AA);
        run_copy("R9", 20'hF_FFFD, 20'hF_FFFE, 5, 0, 0);

        // R4: upper bits of the high slots are ignored.
        preload(16'h1234);
        set_prm(16'h0300, 16'hFFF2, 16'h0900, 16'hABC4, 16'd3, 16'h0, 16'h0);
        issue(16'h0006);
        wait_idle();
        model_copy(20'h2_0300, 20'h4_0900, 3, 1, 3);
        mem_check("R4");
        check(first_wr == 20'h4_0900, "R4", "pointer high nibble", first_wr, 20'h4_0900);

        // R3: bits 15:7 of the command word are ignored (0x8086 runs linear copy).
        preload(16'h0F0F);
        set_prm(16'h0010, 16'h0, 16'h0020, 16'h0, 16'd4, 16'h0, 16'h0);
        issue(16'h8086);
        wait_idle();
        model_copy(20'h0010, 20'h0020, 4, 1, 4);
        mem_check("R3");
        check(acc_cnt == 8, "R3", "upper code bits ignored", acc_cnt, 8);

        // R3: no-op and drawing codes, R8: zero sizes.
        preload(16'h7777);
        set_prm(16'h0010, 16'h0, 16'h0020, 16'h0, 16'd4, 16'd2, 16'h0);
        for (int c = 0; c <= 5; c++) run_empty("R3", 16'(c));
        run_empty("R3", 16'h0009);
        run_empty("R3", 16'h007F);
        set_prm(16'h0010, 16'h0, 16'h0020, 16'h0, 16'd0, 16'd2, 16'h0);
        run_empty("R8", 16'h0006);
        run_empty("R8", 16'h0007);
        set_prm(16'h0010, 16'h0, 16'h0020, 16'h0, 16'd4, 16'd0, 16'h0);
        run_empty("R8", 16'h0007);
        set_prm(16'h0010, 16'h0, 16'd0, 16'hBEEF, 16'h0, 16'h0, 16'h0);
        run_empty("R8", 16'h0008);
        mem_check("R8");

        // R10: a fill written mid-copy is ignored.
        lat = 2;
        preload(16'h2468);
        set_prm(16'h0100, 16'h0, 16'h0200, 16'h0, 16'd20, 16'h0, 16'h0);
        issue(16'h0006);
        repeat (5) @(negedge clk);
        check(ready == 1'b0, "R10", "busy during copy", ready, 0);
        set_prm(16'h0200, 16'h0, 16'd10, 16'hDEAD, 16'h0, 16'h0, 16'h0);
        issue(16'h0008);
        wait_idle();
        repeat (10) @(negedge clk);
        model_copy(20'h0100, 20'h0200, 20, 1, 20);
        mem_check("R10");
        check(acc_cnt == 40, "R10", "no extra job", acc_cnt, 40);

        // R11: request held stable until acknowledge throughout the run.
        check(hold_err == 0, "R11", "handshake violations", hold_err, 0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule